// File: doc/BRIEF.md
# General-Purpose Compare Timer

This block is a memory-mapped free-running timer for a system-on-chip. A counter advances on ticks from one of several clock-enable sources. Each source arrives as a single-cycle enable pulse on the one system clock. The ticks pass through a programmable prescaler before they reach the counter. The counter is compared against several compare registers. When the counter steps onto a compare value, the matching status flag is set. The interrupt output is active while any flagged channel also has its interrupt enable set.

Software uses a simple register bus. Read data is combinational from the address whenever the read strobe is high. The timer is set up through the control word, which holds:
- the run bit;
- the source selection;
- the run-while-asleep bits;
- a stored free-run bit;
- a gate for the fast source;
- a self-clearing soft-reset bit.

A soft reset lasts a fixed number of system-clock cycles. It clears the timer state but keeps the control fields that choose the source and the low-power behaviour.

Register offsets:

| Offset | Register |
|--------|----------|
| 0x00 | control |
| 0x04 | prescaler |
| 0x08 | status |
| 0x0C | interrupt enable |
| 0x10 + 4·i | compare i |
| 0x24 | counter (read-only) |

Control bits:

| Bit(s) | Field |
|--------|-------|
| 0 | run |
| 3:1 | source |
| 4 | stop-run |
| 5 | doze-run |
| 6 | wait-run |
| 7 | debug-run |
| 8 | free-run (stored only) |
| 9 | fast gate |
| 15 | soft reset |

Source codes:

| Code | Source |
|------|--------|
| 0 | none |
| 1 | peripheral |
| 2 | fast peripheral |
| 3 | external |
| 4 | slow |
| 5 | fast |

Top module: `gp_timer`

## Requirements
- R1: With prescaler value P, the counter advances once per P+1 qualified ticks of the selected source. The prescaler counts from zero after any soft reset.
- R2: Control bits [3:1] select the tick source by code: 0 none, 1 peripheral, 2 fast peripheral, 3 external, 4 slow, 5 fast. Unselected sources have no effect. Code 0 never counts. Code 5 counts only while control bit 9 is set.
- R3: The counter does not change while control bit 0 (run) is clear.
- R4: Bits 4, 5, 6 and 7 of the control word pair with the stop, doze, wait and debug inputs. If any of these inputs is high while its paired bit is clear, the counter freezes. If the paired bit is set, counting continues.
- R5: On the clock edge where the counter steps onto compare register i, status bit i (bits [NUM_CMP-1:0] at 0x08) is set. The counter keeps counting and is not reloaded.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A match in the same cycle wins over the clear.
- R7: The interrupt output is high exactly when some status bit and the interrupt-enable bit at the same position (0x0C) are both set.
- R8: The counter wraps from all-ones to zero. Writes to the counter offset 0x24 are ignored.
- R9: Writing control bit 15 starts a soft reset. Bit 15 reads 1 for exactly RST_CYC (4) cycles and then reads 0. The soft reset has these effects:
  - clears run, the prescaler, status, interrupt enables and the counter;
  - sets the compare registers to all-ones;
  - keeps control bits [9:1].
- R10: While a soft reset is in progress, writes to any register other than control are ignored.
- R11: After the reset input these values hold:
  - control, prescaler, status, interrupt enable and counter read 0;
  - the compare registers read all-ones;
  - the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, zero when bus_re is low |
| tick_periph | input | 1 | Peripheral clock tick enable |
| tick_periph_hi | input | 1 | Fast peripheral clock tick enable |
| tick_ext | input | 1 | External clock tick enable |
| tick_slow | input | 1 | Slow clock tick enable |
| tick_fast | input | 1 | Fast clock tick enable, gated by control bit 9 |
| lp_stop | input | 1 | Stop-mode indication |
| lp_doze | input | 1 | Doze-mode indication |
| lp_wait | input | 1 | Wait-mode indication |
| lp_debug | input | 1 | Debug-halt indication |
| irq | output | 1 | Level interrupt |

## Verification
Several properties are checked on every cycle:
- the counter steps by exactly one, including the wrap;
- the counter holds while run is clear;
- no step happens while a frozen low-power input or an ungated fast source blocks it;
- a status flag rises only on a compare match;
- a written-one clear takes effect;
- state stays cleared and guarded against writes during a soft reset.

Other behaviour needs the bench's scenarios:
- that each prescaler value gives the right division;
- that a source code picks the correct tick input;
- the exact length of the busy window seen through the control read;
- which control fields survive a soft reset;
- the interrupt level when flags and enables are combined in different ways.

// File: rtl/gpt_pkg.sv
`timescale 1ns/1ps
package gpt_pkg;

    // Register byte offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_PRE  = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_IEN  = 'h0C;
    localparam int OFS_CMP0 = 'h10;
    localparam int OFS_CNT  = 'h24;

    // Control word bit positions
    localparam int C_SWR    = 15;
    localparam int C_FIELDS = 10;

    typedef enum logic [2:0] {
        SRC_OFF       = 3'd0,
        SRC_PERIPH    = 3'd1,
        SRC_PERIPH_HI = 3'd2,
        SRC_EXT       = 3'd3,
        SRC_SLOW      = 3'd4,
        SRC_FAST      = 3'd5
    } src_e;

    // Packed so that the struct maps directly onto control bits [9:0]
    typedef struct packed {
        logic gate;      // 9: fast source gate
        logic free;      // 8: free-run select (stored)
        logic dbg_run;   // 7
        logic wait_run;  // 6
        logic doze_run;  // 5
        logic stop_run;  // 4
        src_e src;       // 3:1
        logic run;       // 0
    } ctrl_t;

endpackage

// File: rtl/gpt_tick_gen.sv
`timescale 1ns/1ps
module gpt_tick_gen
    import gpt_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  ctrl_t            ctrl,
    input  logic [PRE_W-1:0] prescale,
    input  logic             tick_periph,
    input  logic             tick_periph_hi,
    input  logic             tick_ext,
    input  logic             tick_slow,
    input  logic             tick_fast,
    input  logic             lp_stop,
    input  logic             lp_doze,
    input  logic             lp_wait,
    input  logic             lp_debug,
    output logic             step
);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic             src_tick;
    logic             frozen;
    logic             qual;
    logic             unused_free;

    assign unused_free = ctrl.free;

    always_comb begin
        case (ctrl.src)
            SRC_PERIPH:    src_tick = tick_periph;
            SRC_PERIPH_HI: src_tick = tick_periph_hi;
            SRC_EXT:       src_tick = tick_ext;
            SRC_SLOW:      src_tick = tick_slow;
            SRC_FAST:      src_tick = tick_fast & ctrl.gate;
            default:       src_tick = 1'b0;
        endcase
    end

    assign frozen = (lp_stop  & ~ctrl.stop_run) |
                    (lp_doze  & ~ctrl.doze_run) |
                    (lp_wait  & ~ctrl.wait_run) |
                    (lp_debug & ~ctrl.dbg_run);

    assign qual = ctrl.run & src_tick & ~frozen;

    always_comb begin
        pre_d = pre_q;
        step  = 1'b0;
        if (clr) begin
            pre_d = '0;
        end else if (qual) begin
            if (pre_q >= prescale) begin
                step  = 1'b1;
                pre_d = '0;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3: no step without run
    a_r3_no_step_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !step);
    // R4: a frozen low-power input blocks stepping
    a_r4_wait_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_wait && !ctrl.wait_run) |-> !step);
    // R2: fast source needs its gate
    a_r2_fast_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src == SRC_FAST && !ctrl.gate) |-> !step);

endmodule

// File: rtl/gpt_compare.sv
`timescale 1ns/1ps
module gpt_compare #(
    parameter int NUM_CMP = 3,
    parameter int CNT_W   = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            step,
    input  logic [CNT_W-1:0]                cnt_next,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp,
    input  logic [NUM_CMP-1:0]              w1c,
    output logic [NUM_CMP-1:0]              status
);

    logic [NUM_CMP-1:0] hit;
    logic [NUM_CMP-1:0] st_d, st_q;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
        assign hit[i] = step && (cnt_next == cmp[i]);

        always_comb begin
            if (clr) st_d[i] = 1'b0;
            else     st_d[i] = (st_q[i] & ~w1c[i]) | hit[i];
        end

        // R5: a flag only rises on a compare match
        a_r5_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q[i]) |-> $past(hit[i]));
        // R6: a written one clears the flag when no match competes
        a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (w1c[i] && !hit[i]) |=> !st_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;

endmodule

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
module gp_timer
    import gpt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int PRE_W   = 12,
    parameter int NUM_CMP = 3,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_periph,
    input  logic              tick_periph_hi,
    input  logic              tick_ext,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              lp_stop,
    input  logic              lp_doze,
    input  logic              lp_wait,
    input  logic              lp_debug,
    output logic              irq
);

    localparam int RC_W = $clog2(RST_CYC + 1);

    typedef struct packed {
        ctrl_t                          ctrl;
        logic [PRE_W-1:0]               pre;
        logic [NUM_CMP-1:0]             ien;
        logic [CNT_W-1:0]               cnt;
        logic [NUM_CMP-1:0][CNT_W-1:0]  cmp;
        logic [RC_W-1:0]                rcnt;
    } regs_t;

    regs_t              r_d, r_q;
    logic               busy;
    logic               swr_go;
    logic               clr;
    logic               step;
    logic [CNT_W-1:0]   cnt_next;
    logic [NUM_CMP-1:0] status;
    logic [NUM_CMP-1:0] w1c;
    logic [DATA_W-1:0]  rd;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign busy     = (r_q.rcnt != '0);
    assign swr_go   = bus_we && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[C_SWR];
    assign clr      = busy | swr_go;
    assign cnt_next = r_q.cnt + 1'b1;
    assign w1c      = (bus_we && !busy && bus_addr == ADDR_W'(OFS_STAT))
                      ? bus_wdata[NUM_CMP-1:0] : '0;

    gpt_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr            (clr),
        .ctrl           (r_q.ctrl),
        .prescale       (r_q.pre),
        .tick_periph    (tick_periph),
        .tick_periph_hi (tick_periph_hi),
        .tick_ext       (tick_ext),
        .tick_slow      (tick_slow),
        .tick_fast      (tick_fast),
        .lp_stop        (lp_stop),
        .lp_doze        (lp_doze),
        .lp_wait        (lp_wait),
        .lp_debug       (lp_debug),
        .step           (step)
    );

    gpt_compare #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .step     (step),
        .cnt_next (cnt_next),
        .cmp      (r_q.cmp),
        .w1c      (w1c),
        .status   (status)
    );

    // Next-state logic
    always_comb begin
        r_d = r_q;
        if (busy) r_d.rcnt = r_q.rcnt - 1'b1;

        if (bus_we && bus_addr == ADDR_W'(OFS_CTRL)) begin
            r_d.ctrl = ctrl_t'(bus_wdata[C_FIELDS-1:0]);
            if (swr_go) begin
                r_d.ctrl.run = 1'b0;
                r_d.rcnt     = RC_W'(RST_CYC);
            end
        end

        if (clr) begin
            r_d.pre = '0;
            r_d.ien = '0;
            r_d.cnt = '0;
            r_d.cmp = '1;
        end else begin
            if (step) r_d.cnt = cnt_next;
            if (bus_we && bus_addr == ADDR_W'(OFS_PRE))
                r_d.pre = bus_wdata[PRE_W-1:0];
            if (bus_we && bus_addr == ADDR_W'(OFS_IEN))
                r_d.ien = bus_wdata[NUM_CMP-1:0];
            for (int i = 0; i < NUM_CMP; i++) begin
                if (bus_we && bus_addr == ADDR_W'(OFS_CMP0 + 4 * i))
                    r_d.cmp[i] = bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cmp <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    // Read mux
    always_comb begin
        rd = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            rd[C_FIELDS-1:0] = r_q.ctrl;
            rd[C_SWR]        = busy;
        end
        if (bus_addr == ADDR_W'(OFS_PRE))  rd[PRE_W-1:0]   = r_q.pre;
        if (bus_addr == ADDR_W'(OFS_STAT)) rd[NUM_CMP-1:0] = status;
        if (bus_addr == ADDR_W'(OFS_IEN))  rd[NUM_CMP-1:0] = r_q.ien;
        if (bus_addr == ADDR_W'(OFS_CNT))  rd[CNT_W-1:0]   = r_q.cnt;
        for (int i = 0; i < NUM_CMP; i++) begin
            if (bus_addr == ADDR_W'(OFS_CMP0 + 4 * i)) rd[CNT_W-1:0] = r_q.cmp[i];
        end
    end

    assign bus_rdata = bus_re ? rd : '0;
    assign irq       = |(status & r_q.ien);

    // R8: every step moves the counter by exactly one, wrapping
    a_r8_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (r_q.cnt == $past(r_q.cnt) + 1'b1));
    // R3: the counter holds while run is clear
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.ctrl.run && !clr) |=> $stable(r_q.cnt));
    // R9: state stays cleared during a soft reset
    a_r9_held_clear: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.cnt == '0 && r_q.ien == '0 && status == '0));
    // R10: non-control writes have no effect while busy
    a_r10_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && bus_addr != ADDR_W'(OFS_CTRL)) |=> $stable(r_q.pre));

endmodule

// File: tb/sim_gp_timer.sv
`timescale 1ns/1ps
module sim_gp_timer;

    localparam int CW = 10;
    localparam logic [31:0] CMAX = 32'h3FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        t_per = 0, t_hi = 0, t_ext = 0, t_slow = 0, t_fast = 0;
    logic        lp_stop = 0, lp_doze = 0, lp_wait = 0, lp_debug = 0;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    gp_timer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .tick_periph(t_per), .tick_periph_hi(t_hi), .tick_ext(t_ext),
        .tick_slow(t_slow), .tick_fast(t_fast),
        .lp_stop(lp_stop), .lp_doze(lp_doze), .lp_wait(lp_wait), .lp_debug(lp_debug),
        .irq(irq)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic        gate;
        logic [3:0]  pre;
        logic [4:0]  mask;   // {fast, slow, ext, periph_hi, periph}
        logic [11:0] n;
        logic [11:0] expc;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{3'd1, 1'b0, 4'd0, 5'b00001, 12'd10, 12'd10},
        '{3'd1, 1'b0, 4'd3, 5'b00001, 12'd10, 12'd2},
        '{3'd3, 1'b0, 4'd0, 5'b00001, 12'd8,  12'd0},
        '{3'd3, 1'b0, 4'd1, 5'b00100, 12'd9,  12'd4},
        '{3'd5, 1'b0, 4'd0, 5'b10000, 12'd8,  12'd0},
        '{3'd5, 1'b1, 4'd0, 5'b10000, 12'd8,  12'd8},
        '{3'd0, 1'b0, 4'd0, 5'b11111, 12'd8,  12'd0},
        '{3'd4, 1'b0, 4'd2, 5'b01000, 12'd9,  12'd3},
        '{3'd2, 1'b0, 4'd0, 5'b00010, 12'd5,  12'd5}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #2;
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic ticks(input logic [4:0] m, input int n);
        @(negedge clk);
        {t_fast, t_slow, t_ext, t_hi, t_per} = m;
        repeat (n) @(negedge clk);
        {t_fast, t_slow, t_ext, t_hi, t_per} = '0;
    endtask

    task automatic soft_reset();
        wr(8'h00, 32'h8000);
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset values
        rd(8'h00, v); chk("R11 ctrl", v, 0);
        rd(8'h04, v); chk("R11 pre", v, 0);
        rd(8'h08, v); chk("R11 status", v, 0);
        rd(8'h0C, v); chk("R11 ien", v, 0);
        rd(8'h10, v); chk("R11 cmp0", v, CMAX);
        rd(8'h24, v); chk("R11 cnt", v, 0);
        chk("R11 irq", {31'b0, irq}, 0);

        // R1 / R2: source selection and prescaler table
        for (int k = 0; k < 9; k++) begin
            soft_reset();
            wr(8'h04, {28'b0, VEC[k].pre});
            wr(8'h00, {22'b0, VEC[k].gate, 5'b0, VEC[k].sel, 1'b1});
            ticks(VEC[k].mask, int'(VEC[k].n));
            rd(8'h24, v);
            chk($sformatf("R1/R2 vector %0d", k), v, {20'b0, VEC[k].expc});
        end

        // R3: run clear, counter holds
        soft_reset();
        wr(8'h00, 32'h0002);
        ticks(5'b00001, 6);
        rd(8'h24, v); chk("R3 no run", v, 0);

        // R4: wait input freezes unless its run bit is set
        wr(8'h00, 32'h0003);
        lp_wait = 1'b1;
        ticks(5'b00001, 6);
        rd(8'h24, v); chk("R4 frozen", v, 0);
        wr(8'h00, 32'h0043);
        ticks(5'b00001, 6);
        rd(8'h24, v); chk("R4 wait run", v, 6);
        lp_stop = 1'b1;
        wr(8'h00, 32'h0053);
        ticks(5'b00001, 2);
        rd(8'h24, v); chk("R4 stop run", v, 8);
        lp_wait = 1'b0; lp_stop = 1'b0;

        // R5 / R6 / R7: compare, W1C, interrupt
        soft_reset();
        wr(8'h10, 5);
        wr(8'h14, 6);
        wr(8'h0C, 1);
        wr(8'h00, 32'h0003);
        ticks(5'b00001, 5);
        rd(8'h08, v); chk("R5 match ch0", v, 1);
        chk("R7 irq on", {31'b0, irq}, 1);
        ticks(5'b00001, 3);
        rd(8'h24, v); chk("R5 no reload", v, 8);
        rd(8'h08, v); chk("R5 match ch1", v, 3);
        wr(8'h08, 0);
        rd(8'h08, v); chk("R6 write zero", v, 3);
        wr(8'h08, 1);
        rd(8'h08, v); chk("R6 write one", v, 2);
        chk("R7 irq masked", {31'b0, irq}, 0);
        wr(8'h0C, 2);
        chk("R7 irq ch1", {31'b0, irq}, 1);

        // R8: wrap and read-only counter
        soft_reset();
        wr(8'h00, 32'h0003);
        ticks(5'b00001, 1027);
        rd(8'h24, v); chk("R8 wrap", v, 3);
        rd(8'h08, v); chk("R8 all-ones match", v, 7);
        wr(8'h24, 32'h55);
        rd(8'h24, v); chk("R8 read-only", v, 3);

        // R9: soft reset window and preserved fields
        wr(8'h04, 3);
        wr(8'h0C, 7);
        wr(8'h00, 32'h0313);
        wr(8'h00, 32'h8313);
        for (int c = 0; c < 4; c++) begin
            if (c > 0) @(negedge clk);
            rd(8'h00, v); chk($sformatf("R9 busy cycle %0d", c), v, 32'h8312);
        end
        @(negedge clk);
        rd(8'h00, v); chk("R9 done", v, 32'h0312);
        rd(8'h04, v); chk("R9 pre cleared", v, 0);
        rd(8'h0C, v); chk("R9 ien cleared", v, 0);
        rd(8'h24, v); chk("R9 cnt cleared", v, 0);
        rd(8'h10, v); chk("R9 cmp set", v, CMAX);

        // R10: writes ignored while busy
        wr(8'h00, 32'h8000);
        wr(8'h0C, 7);
        wr(8'h10, 3);
        repeat (4) @(negedge clk);
        rd(8'h0C, v); chk("R10 ien ignored", v, 0);
        rd(8'h10, v); chk("R10 cmp ignored", v, CMAX);

        done = 1;
        summary();
        $finish;
    end

endmodule